// File: doc/BRIEF.md
# Ramp-Weighted Streaming FIR Filter

This block is a 16-tap integer FIR filter that runs continuously. It sits between two FIFOs. It takes 32-bit signed samples from the read side of an upstream FIFO and writes one 32-bit result for each sample it takes into the write side of a downstream FIFO. The tap weights are fixed and grow linearly across the delay line. The newest sample carries the largest weight and the oldest sample carries weight zero. A result is only released as a real sum once a nonzero sample sits in the oldest tap. Until then, and whenever the oldest tap holds zero, the result written is zero.

The upstream FIFO is assumed to be show-ahead: `in_data` is valid whenever `in_empty` is low, and asserting `in_rd` consumes that word at the clock edge. The downstream FIFO takes `out_data` on every edge where `out_wr` is high. The `start` input is a global run enable, and when it is low nothing moves. The filter accepts one sample per clock when both FIFOs allow it. It stalls without loss or duplication when the input runs dry or the output fills up.

Top module: `ramp_fir_stream`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_wr` is low. The delay line restarts from all-zero contents.
- R2: While `start` is low, `in_rd` and `out_wr` both stay low, and no sample is taken or result written.
- R3: `in_rd` is never high while `in_empty` is high, and `out_wr` is never high while `out_full` is high.
- R4: With `start` high, `in_empty` low and `out_full` low, `in_rd` is high on every cycle, so one sample is accepted per clock.
- R5: With `start` high and `out_full` low throughout, the result for a sample is written exactly 3 cycles after the cycle in which that sample was read (`in_rd` high).
- R6: The result for sample n equals the sum over k = 0..15 of k times sample (n-15+k). The newest sample (n) has weight 15. The arithmetic is 32-bit two's complement with wrap-around.
- R7: If sample (n-15) is zero, or does not exist yet (n < 15, treated as zero), result n is exactly 0.
- R8: Results leave in input order, one per accepted sample, under any pattern of `in_empty`, `out_full` and `start`, with none lost or duplicated.
- R9: When a result is waiting and `out_full` is high, the whole pipeline freezes: `in_rd` stays low and `out_data` holds its value until the write happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Global run enable |
| in_data | input | 32 | Head word of upstream FIFO (show-ahead) |
| in_empty | input | 1 | Upstream FIFO has no word |
| in_rd | output | 1 | Pops the upstream FIFO at this edge |
| out_data | output | 32 | Filtered result |
| out_full | input | 1 | Downstream FIFO cannot take a word |
| out_wr | output | 1 | Pushes `out_data` into the downstream FIFO at this edge |

## Verification
A sample read in cycle c shifts into the delay line at the end of c. Its weighted products register at the end of c+1 and its sum registers at the end of c+2, so its write appears in cycle c+3 when no output stall intervenes. The bench samples both handshakes at the falling edge of each cycle, the moment just before the edge that acts on them. It tags every read with its cycle number and, in phases that never assert `out_full`, compares the write cycle with the read cycle plus 3. In the other phases it checks only order and value, because a full output pushes results later by the number of frozen cycles, and it then checks the frozen cycles for a held `out_data` and no reads.

// File: rtl/rfir_pkg.sv
package rfir_pkg;
  localparam int unsigned RFIR_W    = 32;
  localparam int unsigned RFIR_TAPS = 16;
  // cycles from the read cycle to the write cycle when nothing stalls
  localparam int unsigned RFIR_LAT  = 3;

  // weight of a delay-line entry, indexed by its distance from the oldest tap
  function automatic logic [RFIR_W-1:0] ramp_weight(input int unsigned dist_from_oldest);
    return RFIR_W'(dist_from_oldest);
  endfunction
endpackage

// File: rtl/rfir_tapline.sv
module rfir_tapline #(
  parameter int unsigned W    = rfir_pkg::RFIR_W,
  parameter int unsigned TAPS = rfir_pkg::RFIR_TAPS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   shift,
  input  logic [W-1:0]           din,
  output logic [TAPS-1:0][W-1:0] taps   // [0] oldest, [TAPS-1] newest
);
  localparam int unsigned NEWEST = TAPS - 1;

  always_ff @(posedge clk) begin
    if (rst) taps[NEWEST] <= '0;
    else if (shift) taps[NEWEST] <= din;
  end

  for (genvar k = 0; k < NEWEST; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) taps[k] <= '0;
      else if (shift) taps[k] <= taps[k+1];
    end
  end
endmodule

// File: rtl/rfir_mac.sv
module rfir_mac #(
  parameter int unsigned W    = rfir_pkg::RFIR_W,
  parameter int unsigned TAPS = rfir_pkg::RFIR_TAPS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   adv,
  input  logic                   tap_vld,
  input  logic [TAPS-1:0][W-1:0] taps,
  output logic [W-1:0]           res_data,
  output logic                   res_vld
);
  logic [TAPS-1:0][W-1:0] prod_q;
  logic                   live_q;
  logic                   prod_vld_q;
  logic [W-1:0]           acc;

  for (genvar k = 0; k < TAPS; k++) begin : g_mul
    always_ff @(posedge clk) begin
      if (rst) prod_q[k] <= '0;
      else if (adv) prod_q[k] <= W'(taps[k] * rfir_pkg::ramp_weight(k));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q     <= 1'b0;
      prod_vld_q <= 1'b0;
    end else if (adv) begin
      live_q     <= (taps[0] != '0);
      prod_vld_q <= tap_vld;
    end
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++) acc = acc + prod_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_data <= '0;
      res_vld  <= 1'b0;
    end else if (adv) begin
      res_data <= live_q ? acc : '0;
      res_vld  <= prod_vld_q;
    end
  end
endmodule

// File: rtl/rfir_ctrl.sv
module rfir_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic in_empty,
  input  logic out_full,
  input  logic res_vld,
  output logic adv,
  output logic take,
  output logic push,
  output logic tap_vld
);
  assign adv  = start && !(res_vld && out_full);
  assign take = adv && !in_empty;
  assign push = adv && res_vld;

  always_ff @(posedge clk) begin
    if (rst) tap_vld <= 1'b0;
    else if (adv) tap_vld <= take;
  end
endmodule

// File: rtl/ramp_fir_stream.sv
module ramp_fir_stream #(
  parameter int unsigned W    = rfir_pkg::RFIR_W,
  parameter int unsigned TAPS = rfir_pkg::RFIR_TAPS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] in_data,
  input  logic         in_empty,
  output logic         in_rd,
  output logic [W-1:0] out_data,
  input  logic         out_full,
  output logic         out_wr
);
  logic                   adv;
  logic                   tap_vld;
  logic                   res_vld;
  logic [TAPS-1:0][W-1:0] taps;

  rfir_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .in_empty (in_empty),
    .out_full (out_full),
    .res_vld  (res_vld),
    .adv      (adv),
    .take     (in_rd),
    .push     (out_wr),
    .tap_vld  (tap_vld)
  );

  rfir_tapline #(.W(W), .TAPS(TAPS)) u_line (
    .clk   (clk),
    .rst   (rst),
    .shift (in_rd),
    .din   (in_data),
    .taps  (taps)
  );

  rfir_mac #(.W(W), .TAPS(TAPS)) u_mac (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .tap_vld  (tap_vld),
    .taps     (taps),
    .res_data (out_data),
    .res_vld  (res_vld)
  );
endmodule

// File: rtl/rfir_chk.sv
module rfir_chk #(
  parameter int unsigned W = rfir_pkg::RFIR_W
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         in_empty,
  input logic         in_rd,
  input logic         out_full,
  input logic         out_wr,
  input logic [W-1:0] out_data,
  input logic         res_vld
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !out_wr);

  // R2
  halt_no_io_chk: assert property (@(posedge clk) disable iff (rst)
    !start |-> (!in_rd && !out_wr));

  // R3
  no_read_empty_chk: assert property (@(posedge clk) disable iff (rst)
    in_rd |-> !in_empty);

  // R3
  no_write_full_chk: assert property (@(posedge clk) disable iff (rst)
    out_wr |-> !out_full);

  // R4
  full_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !in_empty && !out_full) |-> in_rd);

  // R9
  freeze_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    (res_vld && out_full) |-> !in_rd);

  // R9
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (res_vld && out_full) |=> (res_vld && $stable(out_data)));
endmodule

bind ramp_fir_stream rfir_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .in_empty (in_empty),
  .in_rd    (in_rd),
  .out_full (out_full),
  .out_wr   (out_wr),
  .out_data (out_data),
  .res_vld  (res_vld)
);

// File: tb/ramp_fir_stream_test.sv
module ramp_fir_stream_test;
  localparam int NS  = 1200;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] in_data;
  logic        in_empty = 1'b1;
  logic        in_rd;
  logic [31:0] out_data;
  logic        out_full = 1'b0;
  logic        out_wr;

  int checks = 0;
  int fails  = 0;
  int nrd = 0, nwr = 0, cyc = 0;
  int rd_cyc [NS];
  bit lat_mode = 1'b0;
  bit done = 1'b0;
  logic [15:0] lf = 16'hACE1;

  always #2 clk = ~clk;

  ramp_fir_stream uut (
    .clk(clk), .rst(rst), .start(start), .in_data(in_data), .in_empty(in_empty),
    .in_rd(in_rd), .out_data(out_data), .out_full(out_full), .out_wr(out_wr)
  );

  function automatic logic [31:0] sval(input int i);
    case (i % 9)
      0: return 32'h0;
      1: return 32'h7FFF_FFFF;
      2: return -32'(i * 1237);
      default: return 32'(i) * 32'h9E37_79B1 + 32'd5;
    endcase
  endfunction

  function automatic logic [31:0] expo(input int j);
    logic [31:0] acc;
    if (j < 15) return 32'h0;
    if (sval(j - 15) == 32'h0) return 32'h0;
    acc = 32'h0;
    for (int k = 0; k < 16; k++) acc = acc + 32'(sval(j - 15 + k) * 32'(k));
    return acc;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (in_rd && (in_empty || !start)) chk(1'b0, "R3 read", 1, 0);
    if (out_wr && out_full) chk(1'b0, "R3 write", 1, 0);
    if (out_wr) begin
      // R6 R7 R8: value and order
      chk(out_data == expo(nwr), (nwr < 15 || sval(nwr-15) == 0) ? "R7" : "R6/R8",
          int'(out_data), int'(expo(nwr)));
      if (lat_mode) chk(cyc - rd_cyc[nwr] == LAT, "R5 latency", cyc - rd_cyc[nwr], LAT);
      nwr++;
    end
    if (in_rd) begin
      rd_cyc[nrd] = cyc;
      nrd++;
    end
    cyc++;
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    @(posedge clk);
    #1;
    in_data = sval(nrd);
  endtask

  task automatic set_in(input bit empty);
    in_empty = empty || (nrd >= NS - 2);
  endtask

  initial begin
    int r_rd, r_wr;
    logic [31:0] held;
    bit ok;
    in_data = sval(0);
    // R1: reset state
    repeat (3) step();
    chk(!out_wr && !in_rd, "R1 reset", int'(out_wr), 0);
    rst = 1'b0;
    step();
    chk(!out_wr, "R1 after reset", int'(out_wr), 0);

    // R2: start low with data available
    set_in(1'b0);
    r_rd = nrd; r_wr = nwr;
    repeat (20) step();
    chk(nrd == r_rd && nwr == r_wr, "R2 halt", nrd - r_rd, 0);

    // R4 R5: continuous run
    start = 1'b1; lat_mode = 1'b1;
    r_rd = nrd;
    repeat (60) begin set_in(1'b0); step(); end
    chk(nrd - r_rd == 60, "R4 one per cycle", nrd - r_rd, 60);

    // R5 R8: random empty only
    repeat (150) begin set_in(lf[0] & lf[3]); step(); end
    lat_mode = 1'b0;

    // R9: freeze on full output
    set_in(1'b0);
    repeat (5) step();
    out_full = 1'b1;
    step();
    held = out_data;
    r_rd = nrd; r_wr = nwr; ok = 1'b1;
    repeat (6) begin step(); if (out_data != held) ok = 1'b0; end
    chk(ok, "R9 hold", int'(out_data), int'(held));
    chk(nrd == r_rd && nwr == r_wr, "R9 no read", nrd - r_rd, 0);
    out_full = 1'b0;

    // R8: random empty, full and start
    repeat (500) begin
      set_in(lf[1] & lf[5]);
      out_full = lf[2] & lf[7];
      start    = !(lf[4] & lf[9] & lf[11]);
      step();
    end

    // R2: start drop mid-stream with results pending
    start = 1'b0; set_in(1'b0); out_full = 1'b0;
    r_rd = nrd; r_wr = nwr;
    repeat (8) step();
    chk(nrd == r_rd && nwr == r_wr, "R2 mid-stream halt", nwr - r_wr, 0);

    // R8: drain
    start = 1'b1; in_empty = 1'b1;
    repeat (10) step();
    chk(nwr == nrd, "R8 count", nwr, nrd);
    chk(nrd > 300, "R8 volume", nrd, 300);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule